// File: doc/BRIEF.md
# Group-Serial Multi-Rate Scan Sequencer

This block sequences the shift and capture phases of a core wrapper whose scan cells are split into clock-domain partitions. Every partition belongs to one of three groups, or to none. Only one group shifts at a time. The groups run in ascending order, and the partitions inside the active group shift together, each at its own rate. The rates are the fast clock divided by 1, 2, 4 or 8. No logic sits on a clock net. Each partition's gated shift clock appears as a one-cycle enable pulse in the fast clock domain.

A two-bit group code drives both the one-hot group gating and the wrapper port select. The value zero is reserved for the idle and capture phases. After the last programmed group has shifted, scan-enable drops and a short burst of fast-rate capture enables goes to every assigned partition. The block then returns to idle and raises a done flag. Group lengths, partition membership and rate choices are inputs. They must be held stable while a sequence runs.

Top module: `grp_scan_seq`

## Requirements
- R1: A partition with rate field k (0 to 3) in the active group receives one shift pulse every 2^k fast cycles, and the first pulse falls in the first cycle of its group's phase.
- R2: The group code decodes as follows: code 1 gives gate bit 0, code 2 gives gate bit 1, code 3 gives gate bit 2, and code 0 gives no gate bit. The port select output always equals the code.
- R3: At most one gate bit is high in any cycle. Only partitions whose group field equals the active code receive shift pulses.
- R4: Group g (length field g-1, LEN_W bits each) shifts for len_g slow cycles, counted at the largest rate field among its partitions (kmax). Scan-enable is therefore high for len_g·2^kmax fast cycles, and a partition at rate k receives len_g·2^(kmax-k) pulses.
- R5: Groups with nonzero length shift strictly in the order 1, 2, 3.
- R6: After the last group, scan-enable is low and the code is 0 for CAP_PULSES consecutive cycles. In each of these cycles, every partition with a nonzero group field gets a capture pulse. No capture pulse occurs while scan-enable is high.
- R7: After capture, busy falls and done rises. Done stays high until the next accepted start.
- R8: A start strobe while busy is ignored and leaves the pulse counts and sequence unchanged.
- R9: A group of length zero is skipped and its code never appears. If all lengths are zero, capture follows the start directly.
- R10: After reset, busy, done, scan-enable, gates, code and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| grp_len_i | input | 3*LEN_W | Per-group length in slow cycles; group g in slice g-1 |
| part_grp_i | input | 2*NPART | Per-partition group field (0 = unassigned, 1..3) |
| part_rate_i | input | RW*NPART | Per-partition rate field k, period 2^k |
| grp_code_o | output | 2 | Active group code (0 = idle/capture) |
| grp_gate_o | output | 3 | One-hot group gating |
| scan_en_o | output | 1 | Scan enable, high while shifting |
| shift_pulse_o | output | NPART | Per-partition shift clock enables |
| cap_pulse_o | output | NPART | Per-partition capture clock enables |
| tam_sel_o | output | 2 | Wrapper mux/demux select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |

## Verification
The hardest situation to reach is a group whose slowest member runs at a different rate from its fastest member. Only in that case do the slow-cycle length and the per-partition pulse counts diverge. The same stimulus must also hit a zero-length group in the middle of the sequence and a start strobe that arrives mid-run. Random configurations draw mixed rates and memberships, with lengths that include zero. Directed runs cover the all-zero case, a lone third group at the slowest rate, and a restart attempt during shifting. Pulse spacing is also checked per cycle.

// File: rtl/grp_scan_seq.sv
module grp_scan_seq #(
  parameter int NPART      = 6,
  parameter int LEN_W      = 8,
  parameter int RATES      = 4,
  parameter int CAP_PULSES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [3*LEN_W-1:0]            grp_len_i,
  input  logic [2*NPART-1:0]            part_grp_i,
  input  logic [$clog2(RATES)*NPART-1:0] part_rate_i,
  output logic [1:0]                    grp_code_o,
  output logic [2:0]                    grp_gate_o,
  output logic                          scan_en_o,
  output logic [NPART-1:0]              shift_pulse_o,
  output logic [NPART-1:0]              cap_pulse_o,
  output logic [1:0]                    tam_sel_o,
  output logic                          busy_o,
  output logic                          done_o
);
  localparam int RW = $clog2(RATES);
  localparam int PW = LEN_W + RATES - 1;
  localparam int CW = $clog2(CAP_PULSES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAP} st_t;
  st_t st_q;
  logic [1:0]    code_q;
  logic [PW-1:0] ph_q;
  logic [CW-1:0] cap_q;
  logic          done_q;

  logic [LEN_W-1:0] len_a [4];
  logic [1:0]       first_g, after_g;
  logic [RW-1:0]    kmax;
  logic [PW-1:0]    ph_last;

  always_comb begin
    len_a[0] = '0;
    for (int g = 1; g <= 3; g++) len_a[g] = grp_len_i[(g-1)*LEN_W +: LEN_W];
    first_g = 2'd0;
    after_g = 2'd0;
    for (int g = 3; g >= 1; g--) begin
      if (len_a[g] != '0) first_g = 2'(g);
      if (len_a[g] != '0 && 2'(g) > code_q) after_g = 2'(g);
    end
    kmax = '0;
    for (int p = 0; p < NPART; p++)
      if (part_grp_i[2*p +: 2] == code_q && part_rate_i[RW*p +: RW] > kmax)
        kmax = part_rate_i[RW*p +: RW];
    ph_last = (PW'(len_a[code_q]) << kmax) - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= 2'd0;
      ph_q   <= '0;
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          done_q <= 1'b0;
          ph_q   <= '0;
          cap_q  <= '0;
          if (first_g != 2'd0) begin
            st_q   <= S_SHIFT;
            code_q <= first_g;
          end else st_q <= S_CAP;
        end
        S_SHIFT: if (ph_q == ph_last) begin
          ph_q <= '0;
          if (after_g != 2'd0) code_q <= after_g;
          else begin
            st_q   <= S_CAP;
            code_q <= 2'd0;
            cap_q  <= '0;
          end
        end else ph_q <= ph_q + PW'(1);
        S_CAP: if (cap_q == CW'(CAP_PULSES - 1)) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end else cap_q <= cap_q + CW'(1);
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign grp_code_o = code_q;
  assign tam_sel_o  = code_q;
  assign scan_en_o  = (st_q == S_SHIFT);
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;

  for (genvar g = 0; g < 3; g++) begin : g_gate
    assign grp_gate_o[g] = (code_q == 2'(g + 1));
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    logic [PW-1:0] mask;
    assign mask = (PW'(1) << part_rate_i[RW*p +: RW]) - PW'(1);
    assign shift_pulse_o[p] = scan_en_o && part_grp_i[2*p +: 2] == code_q
                              && (ph_q & mask) == '0;
    assign cap_pulse_o[p]   = (st_q == S_CAP) && part_grp_i[2*p +: 2] != 2'd0;
  end

  assert_gate_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_gate_o));
  assert_shift_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|shift_pulse_o) |-> (scan_en_o && grp_gate_o != 3'b000));
  assert_cap_no_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_pulse_o) |-> (!scan_en_o && grp_code_o == 2'd0));
  assert_group_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && $past(scan_en_o) && grp_code_o != $past(grp_code_o))
      |-> grp_code_o > $past(grp_code_o));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && start_i) |=> (busy_o && !done_o));
endmodule

// File: tb/grp_scan_seq_bench.sv
module grp_scan_seq_bench;
  localparam int NPART = 6, LEN_W = 8, RATES = 4, CAP = 2, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [3*LEN_W-1:0] grp_len_i = '0;
  logic [2*NPART-1:0] part_grp_i = '0;
  logic [RW*NPART-1:0] part_rate_i = '0;
  logic [1:0] grp_code_o, tam_sel_o;
  logic [2:0] grp_gate_o;
  logic scan_en_o, busy_o, done_o;
  logic [NPART-1:0] shift_pulse_o, cap_pulse_o;

  always #5 clk = ~clk;

  grp_scan_seq #(.NPART(NPART), .LEN_W(LEN_W), .RATES(RATES), .CAP_PULSES(CAP)) u_grp_scan_seq (
    .clk, .rst_n, .start_i, .grp_len_i, .part_grp_i, .part_rate_i,
    .grp_code_o, .grp_gate_o, .scan_en_o, .shift_pulse_o, .cap_pulse_o,
    .tam_sel_o, .busy_o, .done_o);

  int checks = 0, fails = 0;
  int glen [4];
  int pgrp [NPART];
  int prate [NPART];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kmax_of(input int g);
    int k = 0;
    for (int p = 0; p < NPART; p++) if (pgrp[p] == g && prate[p] > k) k = prate[p];
    return k;
  endfunction

  function automatic int exp_shift(input int p);
    if (pgrp[p] == 0) return 0;
    return glen[pgrp[p]] * (1 << (kmax_of(pgrp[p]) - prate[p]));
  endfunction

  function automatic int exp_scan_cycles();
    int s = 0;
    for (int g = 1; g <= 3; g++) s += glen[g] * (1 << kmax_of(g));
    return s;
  endfunction

  function automatic int exp_seq();
    int s = 0;
    for (int g = 1; g <= 3; g++) if (glen[g] != 0) s = s * 10 + g;
    return s;
  endfunction

  task automatic run_once(input bit poke_start);
    int sh [NPART];
    int cp [NPART];
    int last_t [NPART];
    int last_c [NPART];
    int scan_cyc = 0, seq = 0, prev_code = 0, gate_err = 0, gap_err = 0, cap_err = 0, cyc = 0;
    bit fin = 0;
    for (int p = 0; p < NPART; p++) begin
      sh[p] = 0; cp[p] = 0; last_t[p] = 0; last_c[p] = 0;
    end
    for (int g = 1; g <= 3; g++) grp_len_i[(g-1)*LEN_W +: LEN_W] = LEN_W'(glen[g]);
    for (int p = 0; p < NPART; p++) begin
      part_grp_i[2*p +: 2] = 2'(pgrp[p]);
      part_rate_i[RW*p +: RW] = RW'(prate[p]);
    end
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (!fin && cyc < 4000) begin
      int code = int'(grp_code_o);
      logic [2:0] eg = (code == 0) ? 3'b000 : 3'(1 << (code - 1));
      if (grp_gate_o != eg || tam_sel_o != grp_code_o) gate_err++;
      if (scan_en_o) scan_cyc++;
      if (code != 0 && code != prev_code) seq = seq * 10 + code;
      prev_code = code;
      for (int p = 0; p < NPART; p++) begin
        if (shift_pulse_o[p]) begin
          sh[p]++;
          if (last_c[p] == code && cyc - last_t[p] != (1 << prate[p])) gap_err++;
          last_t[p] = cyc; last_c[p] = code;
        end
        if (cap_pulse_o[p]) begin
          cp[p]++;
          if (scan_en_o || code != 0) cap_err++;
        end
      end
      if (done_o) fin = 1;
      cyc++;
      if (poke_start && cyc == 3) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(fin, "R7 watchdog/done", int'(fin), 1);
    chk(!busy_o, "R7 busy low at end", int'(busy_o), 0);
    chk(gate_err == 0, "R2 R3 gate decode", gate_err, 0);
    chk(gap_err == 0, "R1 pulse spacing", gap_err, 0);
    chk(scan_cyc == exp_scan_cycles(), "R4 scan-enable cycles", scan_cyc, exp_scan_cycles());
    chk(seq == exp_seq(), "R5 R9 group sequence", seq, exp_seq());
    chk(cap_err == 0, "R6 capture with scan-enable low", cap_err, 0);
    for (int p = 0; p < NPART; p++) begin
      chk(sh[p] == exp_shift(p), poke_start ? "R8 R4 shift count" : "R4 shift count", sh[p], exp_shift(p));
      chk(cp[p] == (pgrp[p] != 0 ? CAP : 0), "R6 capture count", cp[p], (pgrp[p] != 0 ? CAP : 0));
    end
    repeat (2) @(negedge clk);
    chk(done_o, "R7 done held", int'(done_o), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !scan_en_o && grp_code_o == 0 && grp_gate_o == 0
        && shift_pulse_o == 0 && cap_pulse_o == 0, "R10 reset state", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !scan_en_o, "R10 idle after reset", int'(scan_en_o), 0);

    // R9: all groups empty, straight to capture
    glen[1] = 0; glen[2] = 0; glen[3] = 0;
    for (int p = 0; p < NPART; p++) begin pgrp[p] = p % 4; prate[p] = p % 4; end
    run_once(0);
    // R9: only group 3, slowest rate mix
    glen[3] = 3;
    for (int p = 0; p < NPART; p++) begin pgrp[p] = 3; prate[p] = p % 4; end
    run_once(0);
    // R8: restart attempt while shifting, mixed rates in one group
    glen[1] = 2; glen[2] = 0; glen[3] = 4;
    for (int p = 0; p < NPART; p++) begin pgrp[p] = (p < 3) ? 1 : 3; prate[p] = 3 - (p % 4); end
    run_once(1);
    for (int t = 0; t < 20; t++) begin
      for (int g = 1; g <= 3; g++) glen[g] = $urandom_range(0, 5);
      for (int p = 0; p < NPART; p++) begin
        pgrp[p] = $urandom_range(0, 3);
        prate[p] = $urandom_range(0, 3);
      end
      run_once((exp_scan_cycles() > 4) && (t % 3 == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL R7 global watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule